// File: doc/BRIEF.md
# Stereo Line Mode Selector and Microphone Mixer

This block sits in the sample path of an audio chip, after conversion and before output filtering. Each sample period it receives a left and right line sample, two microphone samples and one echo sample as 16-bit signed values. All of these share a single valid strobe. A 3-bit line-mode code chooses what the line pair contributes to the outputs: stereo, left on both channels, right on both channels, the half-sum mono mix, or a vocal-cut signal that removes the centre of the image.

Each microphone passes through its own stepped attenuator, which is set by a 3-bit volume code and ends in mute. The attenuated microphones and the echo sample are then added onto both channels. Every sum saturates to the 16-bit signed range. The result is registered and appears one clock after the strobe, together with an output valid. The mode and volume codes are taken only on the strobe edge, together with the sample they apply to. Between strobes the outputs hold their values whatever the codes do.

Top module: `line_mode_mixer`

## Requirements
- R1: While rst_n is low at a rising clock edge, out_valid, out_left and out_right become 0.
- R2: out_valid is high in exactly the cycle after a cycle with in_valid high. out_left and out_right take the new sample's result on that same edge.
- R3: While in_valid is low, out_left and out_right hold their values. Changes to line_mode, mic_a_vol or mic_b_vol while in_valid is low do not affect the held outputs.
- R4: line_mode 0 passes left to out_left and right to out_right. The reserved codes 5, 6 and 7 behave the same as code 0.
- R5: line_mode 1 places the left sample on both channels. line_mode 2 places the right sample on both channels.
- R6: line_mode 3 places floor((left + right) / 2) on both channels, using an arithmetic shift.
- R7: line_mode 4 places left − right on both channels, saturated to [−32768, 32767].
- R8: Microphone volume codes 0 to 6 scale the sample by floor(sample × k / 32768), with k = 32768, 26029, 20675, 16423, 11627, 8231, 5827 (0, −2, −4, −6, −9, −12, −15 dB).
- R9: Microphone volume code 7 mutes that microphone.
- R10: The echo sample is added unattenuated. Each channel is the line term plus both scaled microphones plus echo, saturated to [−32768, 32767].
- R11: Both scaled microphones are added to both output channels, each with its own volume code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe; codes and samples are taken when high |
| line_mode | input | 3 | Line routing code (0 stereo, 1 left, 2 right, 3 half-sum, 4 vocal cut, 5-7 stereo) |
| mic_a_vol | input | 3 | Volume code of microphone A |
| mic_b_vol | input | 3 | Volume code of microphone B |
| line_left | input | 16 | Left line sample, signed |
| line_right | input | 16 | Right line sample, signed |
| mic_a | input | 16 | Microphone A sample, signed |
| mic_b | input | 16 | Microphone B sample, signed |
| echo_in | input | 16 | Echo sample, signed |
| out_valid | output | 1 | High one cycle after in_valid |
| out_left | output | 16 | Left mixed output, signed |
| out_right | output | 16 | Right mixed output, signed |

## Verification
Two functions can fall in the same cycle. The first is a change of control codes: the codes may change on the very edge that captures a sample, or in the idle cycles just before it. The second is the final saturating sum, which can clip in the same cycle as a clipped vocal-cut difference. The bench changes codes both together with a strobe and in idle cycles. Its behavioural model applies the codes only at strobes, and the registered outputs are compared against the model on every clock. Directed cases drive full-scale opposite line values with loud microphones and echo, so that both clip points act in one sample.

// File: rtl/line_mix_pkg.sv
// Package: shared widths and the microphone attenuation coefficients.
// Assumes samples are two's-complement and gains are Q1.15 multipliers.
package line_mix_pkg;

    localparam int GAIN_FRAC = 15;
    localparam int COEF_W    = GAIN_FRAC + 2;

    typedef enum logic [2:0] {
        LM_STEREO = 3'd0,
        LM_LEFT   = 3'd1,
        LM_RIGHT  = 3'd2,
        LM_HALF   = 3'd3,
        LM_CUT    = 3'd4
    } line_mode_e;

    // Map a 3-bit volume step to its Q1.15 multiplier; the last step mutes.
    function automatic logic [COEF_W-1:0] vol_coef(input logic [2:0] code);
        logic [COEF_W-1:0] k;
        case (code)
            3'd0:    k = COEF_W'(32768);
            3'd1:    k = COEF_W'(26029);
            3'd2:    k = COEF_W'(20675);
            3'd3:    k = COEF_W'(16423);
            3'd4:    k = COEF_W'(11627);
            3'd5:    k = COEF_W'(8231);
            3'd6:    k = COEF_W'(5827);
            default: k = '0;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/mic_scaler.sv
// Module: mic_scaler
// Attenuates one signed sample by a stepped volume code, using a Q1.15
// multiply and a floor shift. Assumes the coefficient never exceeds unity,
// so the result always fits the sample width. The clock is used only by
// the assertion.
module mic_scaler
    import line_mix_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic        [2:0]    vol_i,
    input  logic signed [DW-1:0] smp_i,
    output logic signed [DW-1:0] scaled_o
);
    localparam int PW = DW + COEF_W + 1;

    logic signed [COEF_W:0]  coef_s;
    logic signed [PW-1:0]    prod;
    logic [PW-DW-GAIN_FRAC-1:0] hi_unused;
    logic [GAIN_FRAC-1:0]    lo_unused;

    // Signed product of sample and non-negative coefficient.
    always_comb begin
        coef_s = $signed({1'b0, vol_coef(vol_i)});
        prod   = PW'(smp_i) * PW'(coef_s);
    end

    // Dropping the fraction bits of a two's-complement value gives the floor.
    assign {hi_unused, scaled_o, lo_unused} = prod;

    // R8
    no_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_i[DW-1] |-> (!scaled_o[DW-1] && (scaled_o <= smp_i)));

endmodule

// File: rtl/line_matrix.sv
// Module: line_matrix
// Builds the line contribution to each channel from the mode code:
// pass-through, either side as mono, the floored half-sum, or the
// saturated difference. Assumes the reserved codes fall back to stereo.
module line_matrix
    import line_mix_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic        [2:0]    mode_i,
    input  logic signed [DW-1:0] left_i,
    input  logic signed [DW-1:0] right_i,
    output logic signed [DW-1:0] mix_l_o,
    output logic signed [DW-1:0] mix_r_o
);
    localparam logic signed [DW-1:0] POS_FULL = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] NEG_FULL = {1'b1, {(DW-1){1'b0}}};

    logic signed [DW:0]   hsum;
    logic signed [DW:0]   diff;
    logic signed [DW-1:0] half;
    logic                 half_lsb_unused;
    logic signed [DW-1:0] cut;

    // Widened sum and difference, so that neither can wrap.
    always_comb begin
        hsum = (DW+1)'(left_i) + (DW+1)'(right_i);
        diff = (DW+1)'(left_i) - (DW+1)'(right_i);
    end

    assign {half, half_lsb_unused} = hsum;

    // Clamp the difference when its top two bits disagree.
    always_comb begin
        if (diff[DW] != diff[DW-1]) cut = diff[DW] ? NEG_FULL : POS_FULL;
        else                        cut = diff[DW-1:0];
    end

    // Route according to the mode code.
    always_comb begin
        case (line_mode_e'(mode_i))
            LM_LEFT:  begin mix_l_o = left_i;  mix_r_o = left_i;  end
            LM_RIGHT: begin mix_l_o = right_i; mix_r_o = right_i; end
            LM_HALF:  begin mix_l_o = half;    mix_r_o = half;    end
            LM_CUT:   begin mix_l_o = cut;     mix_r_o = cut;     end
            default:  begin mix_l_o = left_i;  mix_r_o = right_i; end
        endcase
    end

endmodule

// File: rtl/line_mode_mixer.sv
// Module: line_mode_mixer (top)
// Registered stereo mixer. On each valid strobe it routes the line pair
// by mode, adds both attenuated microphones and the echo to each channel,
// saturates, and registers the result with one cycle of latency. Assumes
// the control codes are sampled only on strobe cycles, so each output
// sample uses exactly one set of codes.
module line_mode_mixer
    import line_mix_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NMIC = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic        [2:0]    line_mode,
    input  logic        [2:0]    mic_a_vol,
    input  logic        [2:0]    mic_b_vol,
    input  logic signed [DW-1:0] line_left,
    input  logic signed [DW-1:0] line_right,
    input  logic signed [DW-1:0] mic_a,
    input  logic signed [DW-1:0] mic_b,
    input  logic signed [DW-1:0] echo_in,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_left,
    output logic signed [DW-1:0] out_right
);
    localparam int SW = DW + $clog2(NMIC + 2) + 1;
    localparam logic signed [SW-1:0] SUM_MAX = SW'({1'b0, {(DW-1){1'b1}}});
    localparam logic signed [SW-1:0] SUM_MIN = ~SUM_MAX;
    localparam logic signed [DW-1:0] POS_FULL = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] NEG_FULL = {1'b1, {(DW-1){1'b0}}};

    logic        [2:0]    mic_vol [NMIC];
    logic signed [DW-1:0] mic_smp [NMIC];
    logic signed [DW-1:0] mic_scl [NMIC];
    logic signed [DW-1:0] mix_l, mix_r;
    logic signed [SW-1:0] sum_l, sum_r;
    logic signed [DW-1:0] sat_l, sat_r;

    // Gather the microphone inputs into arrays for the scaler loop.
    always_comb begin
        mic_vol[0] = mic_a_vol;
        mic_vol[1] = mic_b_vol;
        mic_smp[0] = mic_a;
        mic_smp[1] = mic_b;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NMIC; gi++) begin : g_mic
            mic_scaler #(.DW(DW)) u_scaler (
                .clk      (clk),
                .rst_n    (rst_n),
                .vol_i    (mic_vol[gi]),
                .smp_i    (mic_smp[gi]),
                .scaled_o (mic_scl[gi])
            );
        end
    endgenerate

    line_matrix #(.DW(DW)) u_matrix (
        .mode_i  (line_mode),
        .left_i  (line_left),
        .right_i (line_right),
        .mix_l_o (mix_l),
        .mix_r_o (mix_r)
    );

    // Add the echo and every scaled microphone onto both line terms.
    always_comb begin
        sum_l = SW'(mix_l) + SW'(echo_in);
        sum_r = SW'(mix_r) + SW'(echo_in);
        for (int m = 0; m < NMIC; m++) begin
            sum_l = sum_l + SW'(mic_scl[m]);
            sum_r = sum_r + SW'(mic_scl[m]);
        end
    end

    // Clamp both wide sums to the sample range.
    always_comb begin
        if (sum_l > SUM_MAX)      sat_l = POS_FULL;
        else if (sum_l < SUM_MIN) sat_l = NEG_FULL;
        else                      sat_l = sum_l[DW-1:0];
        if (sum_r > SUM_MAX)      sat_r = POS_FULL;
        else if (sum_r < SUM_MIN) sat_r = NEG_FULL;
        else                      sat_r = sum_r[DW-1:0];
    end

    // Output register: load only on a strobe, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_left  <= sat_l;
                out_right <= sat_r;
            end
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_left) && $stable(out_right)));

    // R5
    mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (line_mode == 3'd1 || line_mode == 3'd2))
        |=> (out_left == out_right));

    // R7
    cut_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && line_mode == 3'd4 && line_left == line_right &&
         mic_a_vol == 3'd7 && mic_b_vol == 3'd7 && echo_in == '0)
        |=> (out_left == '0 && out_right == '0));

endmodule

// File: tb/line_mode_mixer_bench.sv
module line_mode_mixer_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [2:0] line_mode = '0, mic_a_vol = '0, mic_b_vol = '0;
    logic signed [15:0] line_left = '0, line_right = '0;
    logic signed [15:0] mic_a = '0, mic_b = '0, echo_in = '0;
    logic out_valid;
    logic signed [15:0] out_left, out_right;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int exp_l = 0, exp_r = 0;
    bit exp_v = 1'b0;
    string exp_tag = "R1";

    always #10 clk = ~clk;

    line_mode_mixer u_line_mode_mixer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .line_mode(line_mode), .mic_a_vol(mic_a_vol), .mic_b_vol(mic_b_vol),
        .line_left(line_left), .line_right(line_right),
        .mic_a(mic_a), .mic_b(mic_b), .echo_in(echo_in),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
    );

    function automatic int clip(int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int atten(int s, int code);
        int k;
        case (code)
            0: k = 32768; 1: k = 26029; 2: k = 20675; 3: k = 16423;
            4: k = 11627; 5: k = 8231;  6: k = 5827;  default: k = 0;
        endcase
        return (s * k) >>> 15;
    endfunction

    task automatic compare();
        checks++;
        if (out_valid !== exp_v || int'(out_left) != exp_l || int'(out_right) != exp_r) begin
            errors++;
            $display("FAIL %s: actual v=%0d l=%0d r=%0d expected v=%0d l=%0d r=%0d",
                     exp_tag, out_valid, out_left, out_right, exp_v, exp_l, exp_r);
        end
    endtask

    // Check the previous cycle's result, then drive a new cycle and model it.
    task automatic step(input bit v, input int md, input int va, input int vb,
                        input int l, input int r, input int ma, input int mb,
                        input int e, input string tag);
        int ll, rr;
        @(negedge clk);
        compare();
        in_valid = v; line_mode = 3'(md); mic_a_vol = 3'(va); mic_b_vol = 3'(vb);
        line_left = 16'(l); line_right = 16'(r); mic_a = 16'(ma); mic_b = 16'(mb);
        echo_in = 16'(e);
        exp_v = v;
        exp_tag = tag;
        if (v) begin
            case (md)
                1: begin ll = l; rr = l; end
                2: begin ll = r; rr = r; end
                3: begin ll = (l + r) >>> 1; rr = ll; end
                4: begin ll = clip(l - r); rr = ll; end
                default: begin ll = l; rr = r; end
            endcase
            exp_l = clip(ll + atten(ma, va) + atten(mb, vb) + e);
            exp_r = clip(rr + atten(ma, va) + atten(mb, vb) + e);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2: watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with inputs active during reset
        in_valid = 1'b1; line_left = 16'sd1234;
        repeat (3) @(posedge clk);
        @(negedge clk); compare();
        in_valid = 1'b0;
        @(negedge clk); compare();
        rst_n = 1'b1;
        // R4: stereo pass-through and the reserved codes
        step(1, 0, 7, 7, 1000, -2000, 0, 0, 0, "R4");
        step(1, 5, 7, 7, -300, 400, 0, 0, 0, "R4");
        step(1, 6, 7, 7, 32767, -32768, 0, 0, 0, "R4");
        step(1, 7, 7, 7, 11, 22, 0, 0, 0, "R4");
        // R5: mono left and mono right
        step(1, 1, 7, 7, 1500, -900, 0, 0, 0, "R5");
        step(1, 2, 7, 7, 1500, -900, 0, 0, 0, "R5");
        // R6: half-sum with odd negative and positive-limit sums
        step(1, 3, 7, 7, 3, -4, 0, 0, 0, "R6");
        step(1, 3, 7, 7, 32767, 32767, 0, 0, 0, "R6");
        step(1, 3, 7, 7, -32768, -32767, 0, 0, 0, "R6");
        // R7: vocal cut, in range and clipped at both ends
        step(1, 4, 7, 7, 5000, 2000, 0, 0, 0, "R7");
        step(1, 4, 7, 7, 30000, -30000, 0, 0, 0, "R7");
        step(1, 4, 7, 7, -30000, 30000, 0, 0, 0, "R7");
        step(1, 4, 7, 7, 777, 777, 0, 0, 0, "R7");
        // R8, R9: every volume step on mic A, then on mic B
        for (int c = 0; c < 8; c++) step(1, 0, c, 7, 0, 0, 10001, 0, 0, c == 7 ? "R9" : "R8");
        for (int c = 0; c < 8; c++) step(1, 0, 7, c, 0, 0, 0, -10001, 0, c == 7 ? "R9" : "R8");
        step(1, 0, 7, 7, 100, 100, 32767, -32768, 0, "R9");
        // R11: both mics reach both channels with separate codes
        step(1, 0, 1, 4, 100, -100, 4000, -6000, 0, "R11");
        step(1, 2, 0, 0, 0, 50, 1000, 2000, 0, "R11");
        // R10: echo unattenuated, and saturation of the final sum
        step(1, 0, 7, 7, 100, -100, 0, 0, 1234, "R10");
        step(1, 0, 0, 0, 20000, -20000, 20000, -20000, 30000, "R10");
        step(1, 4, 0, 0, 30000, -30000, 30000, 30000, 30000, "R10");
        step(1, 4, 0, 0, -30000, 30000, -30000, -30000, -30000, "R10");
        // R3: codes and data change while idle; outputs must hold
        step(1, 0, 0, 0, 1000, 2000, 300, 400, 50, "R2");
        step(0, 4, 3, 3, -9999, 9999, 9999, 9999, 9999, "R3");
        step(0, 1, 6, 2, 8888, -8888, 1, 2, 3, "R3");
        step(0, 3, 7, 7, 1, 1, 1, 1, 1, "R3");
        // R2: code change on the strobe edge itself takes effect at once
        step(1, 1, 2, 5, 700, -700, 1000, 1000, 10, "R2");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
        // Mixed run with random strobes and codes
        for (int i = 0; i < 400; i++)
            step(bit'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
                 int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                 int'($urandom_range(0, 65535)) - 32768, int'($urandom_range(0, 65535)) - 32768,
                 int'($urandom_range(0, 65535)) - 32768, int'($urandom_range(0, 65535)) - 32768,
                 int'($urandom_range(0, 65535)) - 32768, "R10");
        @(negedge clk); compare();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule